// File: doc/BRIEF.md
# Host Mailbox FIFO Register Interface

This block sits between a host register bus and a byte-wide command channel to a system-management microcontroller. The host writes command bytes into a data register. They queue in a transmit FIFO and leave on a valid/ready byte stream. Bytes that the microcontroller sends arrive on a second byte stream. They queue in a receive FIFO, and the host pops them by reading the same data register. On both the read and the write path, the byte sits in bits 15:8 of the 32-bit bus word.

Four conditions describe the channel: transmit FIFO empty, transmit FIFO not full, receive byte arrived, and receive overflow. The status register shows all four. The interrupt register shows them again next to four enable bits. A single interrupt line is raised when any enabled condition is active. The two receive indications are sticky, and the host clears each one by writing a 1 to it in the status register.

A bus access is a one-cycle strobe with a write enable and a 2-bit word offset. Read data is returned in the cycle after the strobe.

Top module: `mbox_host_if`

## Requirements
- R1: After synchronous reset both FIFOs are empty, all enable bits and both sticky flags are clear, irq_o is low, and the interrupt and status registers both read 0x00000003.
- R2: Word offset 0 selects the interrupt register, offset 1 the data register and offset 2 the status register. Offset 3 reads as zero. bus_rdata holds the selected value in the cycle after the read strobe.
- R3: A write to offset 1 queues bus_wdata[15:8] into the transmit FIFO. Bytes leave on tx_data in write order. tx_valid is high whenever the FIFO holds a byte, and tx_data stays stable while tx_valid is high and tx_ready is low.
- R4: The transmit FIFO holds 8 bytes. A data write while it holds 8 bytes is discarded. Status bit 0 (transmit empty) is 1 only with no bytes queued, and status bit 1 (transmit not full) is 0 only with 8 bytes queued.
- R5: Each cycle with rx_valid high and fewer than 8 bytes held stores rx_data. A read of offset 1 returns the oldest byte in bits 15:8, with all other bits 0, and removes that byte. A read with the FIFO empty returns 0 and changes nothing.
- R6: A cycle with rx_valid high while 8 bytes are held drops that byte and sets the sticky overflow flag, status bit 3. rx_ready is low exactly while 8 bytes are held.
- R7: A write to offset 2 clears status bit 2 where the written bit 2 is 1, and clears status bit 3 where the written bit 3 is 1. Written zeros and status bits 0 and 1 are left as they were. A flag that is set and cleared in the same cycle ends up set.
- R8: Status bit 2 (byte arrived) is set by every stored receive byte. It stays set after the FIFO has been read empty, until it is cleared by R7.
- R9: Interrupt register bits 3:0 mirror status bits 3:0, and writes to those bits are ignored. Bits 7:4 are enable bits for the same four conditions in the same order, written and read back as given. Bits 31:8 read 0.
- R10: irq_o is the registered OR over the four conditions of (condition AND enable). It changes one cycle after the condition or enable bit that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| tx_data | output | 8 | Byte toward the microcontroller |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Microcontroller takes the byte |
| rx_data | input | 8 | Byte from the microcontroller |
| rx_valid | input | 1 | Receive byte presented this cycle |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
The assertions rely on two assumptions about the inputs. First, each cycle with rx_valid high carries a new byte, and the sender never holds a byte waiting for rx_ready. Second, the bus strobe lasts exactly one cycle. The bench keeps to both. It drives every strobe and every rx_valid pulse for exactly one clock and lowers them at the next falling edge. It overruns the receive FIFO only on purpose, to provoke the drop case. tx_ready is raised only when the test means the microcontroller to take bytes, which makes the transmit hold property observable.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [1:0] OFS_IRQ  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;

  // condition index, shared by status bits and interrupt request/enable bits
  localparam int C_TXE  = 0;
  localparam int C_TXNF = 1;
  localparam int C_RXNE = 2;
  localparam int C_RXOV = 3;
  localparam int NCOND  = 4;

  localparam int BYTE_W   = 8;
  localparam int BYTE_LSB = 8;   // byte lane inside the bus word
  localparam int BUS_W    = 32;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt != FULLCNT);
  assign do_pop  = pop_i && (cnt != '0);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout_o  = mem[rptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == FULLCNT);
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_store,
  input  logic             rx_drop,
  input  logic             clr_wr,
  input  logic [NCOND-1:0] clr_bits,
  input  logic             en_wr,
  input  logic [NCOND-1:0] en_din,
  input  logic             tx_empty,
  input  logic             tx_full,
  output logic [NCOND-1:0] cond_o,
  output logic [NCOND-1:0] en_q,
  output logic             irq_q
);
  localparam int NSTICKY = 2;
  logic [NSTICKY-1:0] sticky_q;
  logic [NSTICKY-1:0] sticky_set;

  assign sticky_set = {rx_drop, rx_store};

  // one sticky flag per receive condition; set has priority over clear
  for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst) sticky_q[g] <= 1'b0;
      else if (sticky_set[g]) sticky_q[g] <= 1'b1;
      else if (clr_wr && clr_bits[C_RXNE + g]) sticky_q[g] <= 1'b0;
    end
  end

  always_comb begin
    cond_o         = '0;
    cond_o[C_TXE]  = tx_empty;
    cond_o[C_TXNF] = !tx_full;
    cond_o[C_RXNE] = sticky_q[0];
    cond_o[C_RXOV] = sticky_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_din;
      irq_q <= |(cond_o & en_q);
    end
  end
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam int EN_LSB = NCOND;

  logic wr_any, rd_any;
  logic data_wr, data_rd, stat_wr, irq_wr;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_pop;
  logic rx_store, rx_drop;
  logic [BYTE_W-1:0] rx_head;
  logic [NCOND-1:0]  cond, en_q;
  logic [BUS_W-1:0]  rd_mux;
  logic wdata_unused;

  assign wr_any  = bus_sel && bus_we;
  assign rd_any  = bus_sel && !bus_we;
  assign data_wr = wr_any && (bus_addr == OFS_DATA);
  assign data_rd = rd_any && (bus_addr == OFS_DATA);
  assign stat_wr = wr_any && (bus_addr == OFS_STAT);
  assign irq_wr  = wr_any && (bus_addr == OFS_IRQ);
  assign wdata_unused = ^{bus_wdata[BUS_W-1:BYTE_LSB+BYTE_W]};

  assign tx_pop   = tx_ready && !tx_empty;
  assign rx_store = rx_valid && !rx_full;
  assign rx_drop  = rx_valid && rx_full;

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push_i(data_wr), .din_i(bus_wdata[BYTE_LSB +: BYTE_W]),
    .pop_i(tx_pop), .dout_o(tx_data),
    .empty_o(tx_empty), .full_o(tx_full)
  );

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push_i(rx_valid), .din_i(rx_data),
    .pop_i(data_rd), .dout_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full)
  );

  mbox_flags u_flags (
    .clk(clk), .rst(rst),
    .rx_store(rx_store), .rx_drop(rx_drop),
    .clr_wr(stat_wr), .clr_bits(bus_wdata[NCOND-1:0]),
    .en_wr(irq_wr), .en_din(bus_wdata[EN_LSB +: NCOND]),
    .tx_empty(tx_empty), .tx_full(tx_full),
    .cond_o(cond), .en_q(en_q), .irq_q(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_IRQ:  rd_mux[2*NCOND-1:0] = {en_q, cond};
      OFS_DATA: if (!rx_empty) rd_mux[BYTE_LSB +: BYTE_W] = rx_head;
      OFS_STAT: rd_mux[NCOND-1:0] = cond;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_any ? rd_mux : '0;
  end

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;
endmodule

// File: rtl/mbox_host_if_chk.sv
module mbox_host_if_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              irq_o,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [NCOND-1:0]  cond,
  input logic [NCOND-1:0]  en_q,
  input logic              tx_full
);
  logic stat_wr, data_wr;
  assign stat_wr = bus_sel && bus_we && (bus_addr == OFS_STAT);
  assign data_wr = bus_sel && bus_we && (bus_addr == OFS_DATA);

  a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> cond[C_RXOV]);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (cond[C_RXOV] && !(stat_wr && bus_wdata[C_RXOV])) |=> cond[C_RXOV]);

  a_r8_rxne_sticky: assert property (@(posedge clk) disable iff (rst)
    (cond[C_RXNE] && !(stat_wr && bus_wdata[C_RXNE])) |=> cond[C_RXNE]);

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (data_wr && tx_full && !tx_ready) |=> tx_full);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(en_q) != '0));
endmodule

bind mbox_host_if mbox_host_if_chk u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .cond(cond), .en_q(en_q), .tx_full(tx_full)
);

// File: tb/mbox_host_if_bench.sv
module mbox_host_if_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_host_if u_mbox_host_if (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 32'h0000_0003, 4'd1},  // R1 interrupt reg after reset
    '{1'b0, 2'd2, 32'h0000_0003, 4'd1},  // R1 status after reset
    '{1'b0, 2'd3, 32'h0000_0000, 4'd2},  // R2 unused offset
    '{1'b1, 2'd0, 32'h0000_00FF, 4'd9},  // enables on, request bits ignored
    '{1'b0, 2'd0, 32'h0000_00F3, 4'd9},  // R9
    '{1'b1, 2'd1, 32'h1234_AB77, 4'd3},  // push byte AB
    '{1'b0, 2'd2, 32'h0000_0002, 4'd3},  // R3 tx no longer empty
    '{1'b0, 2'd0, 32'h0000_00F2, 4'd9},  // R9 mirror
    '{1'b1, 2'd0, 32'h0000_0000, 4'd9},  // enables off
    '{1'b0, 2'd1, 32'h0000_0000, 4'd5},  // R5 empty receive read
    '{1'b1, 2'd2, 32'h0000_000F, 4'd7},  // W1C all
    '{1'b0, 2'd2, 32'h0000_0002, 4'd7}   // R7 bits 0,1 untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].we) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].data);
      end
    end

    // R3: byte AB waits on the stream until taken
    check("R3 tx_valid", {31'd0, tx_valid}, 32'd1);
    check("R3 tx_data", {24'd0, tx_data}, 32'h AB);
    @(negedge clk);
    check("R3 hold", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'hAB});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check("R3 drained", {31'd0, tx_valid}, 32'd0);

    // R4: fill eight, ninth ignored
    for (int i = 0; i < 8; i++) bus_write(2'd1, {16'd0, 8'(8'h11 * (i + 1)), 8'd0});
    bus_write(2'd1, 32'h0000_EE00);
    bus_read(2'd2, rd);
    check("R4 full status", rd, 32'h0);
    tx_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      check("R4 order", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'(8'h11 * (i + 1))});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R4 ninth dropped", {31'd0, tx_valid}, 32'd0);

    // R5, R8: receive path
    rx_push(8'h5A); rx_push(8'hC3); rx_push(8'h01);
    bus_read(2'd2, rd);
    check("R8 arrived", rd, 32'h7);
    bus_read(2'd1, rd); check("R5 byte0", rd, 32'h0000_5A00);
    bus_read(2'd1, rd); check("R5 byte1", rd, 32'h0000_C300);
    bus_read(2'd1, rd); check("R5 byte2", rd, 32'h0000_0100);
    bus_read(2'd1, rd); check("R5 empty", rd, 32'h0);
    bus_read(2'd2, rd); check("R8 sticky after drain", rd, 32'h7);
    bus_write(2'd2, 32'h4);
    bus_read(2'd2, rd); check("R7 clear arrived", rd, 32'h3);

    // R6: overflow
    for (int i = 0; i < 9; i++) begin
      rx_push(8'(8'h20 + i));
      if (i == 7) check("R6 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    end
    bus_read(2'd2, rd); check("R6 overflow set", rd, 32'hF);
    bus_write(2'd2, 32'h0);
    bus_read(2'd2, rd); check("R7 zero write keeps", rd, 32'hF);
    bus_write(2'd2, 32'h8);
    bus_read(2'd2, rd); check("R7 clear overflow", rd, 32'h7);
    for (int i = 0; i < 8; i++) begin
      bus_read(2'd1, rd);
      check("R6 kept first eight", rd, {16'd0, 8'(8'h20 + i), 8'd0});
    end
    bus_read(2'd1, rd); check("R6 dropped ninth", rd, 32'h0);
    bus_write(2'd2, 32'h4);

    // R10: interrupt timing
    bus_write(2'd0, 32'h40);
    check("R10 idle", {31'd0, irq_o}, 32'd0);
    rx_push(8'h77);
    check("R10 one cycle lag", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R10 raised", {31'd0, irq_o}, 32'd1);
    bus_write(2'd2, 32'h4);
    @(negedge clk);
    check("R10 dropped after clear", {31'd0, irq_o}, 32'd0);
    bus_write(2'd0, 32'h10);
    @(negedge clk);
    check("R10 tx empty enabled", {31'd0, irq_o}, 32'd1);
    bus_write(2'd0, 32'h0);
    @(negedge clk);
    check("R10 disabled", {31'd0, irq_o}, 32'd0);

    // R7: set wins over a same-cycle clear
    rx_valid = 1'b1; rx_data = 8'h99;
    bus_write(2'd2, 32'h4);
    rx_valid = 1'b0;
    bus_read(2'd2, rd); check("R7 set wins", rd, 32'h7);

    // R1: reset in mid-run
    bus_write(2'd0, 32'hF0);
    bus_write(2'd1, 32'h0000_4400);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    bus_read(2'd0, rd); check("R1 irq reg after reset", rd, 32'h3);
    bus_read(2'd2, rd); check("R1 status after reset", rd, 32'h3);
    bus_read(2'd1, rd); check("R1 rx empty after reset", rd, 32'h0);
    check("R1 tx empty after reset", {31'd0, tx_valid}, 32'd0);
    check("R1 irq low after reset", {31'd0, irq_o}, 32'd0);

    done = 1;
    summary();
  end
endmodule